// File: doc/BRIEF.md
# Serial EEPROM Burst Controller (three-wire-plus-chip-select, 16-bit words)

This block is the master side of a four-wire serial EEPROM link: a serial clock, a chip select, a data line toward the memory and a data line back from it. A host asks for a burst read or a burst write of 16-bit words by giving a start address and a word count. The controller turns the request into one bit-serial command frame per word and returns read words on a one-cycle strobe. For a write it asks the host for each word through a valid/ready pair.

Every bit of the serial link occupies one slot. A slot is a low phase of `LO_CYC` system clocks followed by a high phase of `HI_CYC` system clocks, which sets the minimum serial clock times. Write bursts are wrapped by a write-enable frame and a write-disable frame. After each word the controller polls the device until the word is programmed. The poll is bounded, so a device that never reports ready ends the request with an error instead of hanging it.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: Every frame starts with a 1 bit followed by a 2-bit opcode: read = 10, write = 01, special = 00. In a special frame the two most significant address-field bits choose the function (11 = enable writes, 00 = disable writes), and all other address-field bits are sent as 0.
- R2: The address field is `ADDR_W` bits (6 or 8) and follows the opcode, most significant bit first.
- R3: After a read frame's address, 17 slots are clocked with chip select high. The first returned bit is a dummy and is dropped. The next 16 bits form the word, MSB first, which is presented on `rd_data` with a one-cycle `rd_valid`.
- R4: Each write word is taken from the host when both `wr_valid` and `wr_ready` are high. It is shifted out MSB first directly after the address field. Exactly one word is accepted per write frame.
- R5: A write burst begins with one enable frame and ends with one disable frame, and each of these frames is followed by a reset slot. After the burst the device is left write-protected.
- R6: After a write frame's data, chip select stays low for one slot with no serial clock edge. It is then raised, and clock pulses continue until the device's data line reads 1 at the end of a high phase.
- R7: After every frame a reset slot holds chip select low for one complete clock pulse.
- R8: The serial clock is high for exactly `HI_CYC` cycles and low for at least `LO_CYC` cycles. Chip select and the outgoing data bit change only while the serial clock is low.
- R9: A burst visits addresses start, start+1, … start+count−1 modulo 2^`ADDR_W`, with one frame per word.
- R10: If `POLL_MAX` poll pulses pass without a ready indication, `err` is set and the remaining words are skipped. The disable frame is still sent, and `done` is still given. Ready seen on pulse `POLL_MAX` itself is a success.
- R11: A request with a count of 0 completes with `done` and produces no serial activity.
- R12: After reset, `req_ready` is 1 and `ee_cs`, `ee_clk`, `done` and `err` are 0. `done` is a one-cycle pulse, and `err` is cleared when a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_write | input | 1 | 1 = burst write, 0 = burst read |
| req_addr | input | ADDR_W | First word address |
| req_count | input | ADDR_W+1 | Number of words |
| req_ready | output | 1 | Controller idle, ready for a request |
| wr_data | input | 16 | Word to be written |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Controller accepts a write word |
| rd_data | output | 16 | Word read from the device |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 1 | Last request ended by a poll timeout |
| ee_cs | output | 1 | Device chip select |
| ee_clk | output | 1 | Device serial clock |
| ee_dout | output | 1 | Serial data toward the device |
| ee_din | input | 1 | Serial data from the device |

## Verification
The risky coincidence is the poll loop: the device's ready bit and the end of the poll budget can arrive on the same slot, and only the ready bit may win. The bench's device model reports ready on a chosen poll pulse. It is set once to report on exactly the `POLL_MAX`-th pulse, which must end without an error, and once never to report ready, which must end with `err` and a disable frame. The model logs every decoded frame, the poll pulses and the reset pulses. Sweeps over the whole address space compare those logs and the returned words with values computed from the address.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  localparam int WORD_W   = 16;
  localparam int RX_BITS  = WORD_W + 1;
  localparam int LEAD_W   = 3;

  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_SPECIAL = 2'b00;
  localparam logic [1:0] SPEC_WREN   = 2'b11;
  localparam logic [1:0] SPEC_WRDIS  = 2'b00;

  typedef enum logic [2:0] {
    S_IDLE, S_TX, S_RX, S_GAP, S_POLL, S_RST, S_FETCH, S_FIN
  } mw_state_e;

  typedef enum logic [1:0] {
    K_RD, K_WR, K_EN, K_DIS
  } mw_kind_e;
endpackage

// File: rtl/mw_slot_timer.sv
module mw_slot_timer #(
  parameter int LO_CYC = 25,
  parameter int HI_CYC = 75
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic pulse_en,
  output logic sk,
  output logic slot_end
);
  localparam int TOT = LO_CYC + HI_CYC;
  localparam int CW  = $clog2(TOT + 1);

  logic [CW-1:0] cnt;
  logic          last;

  assign last     = (cnt == CW'(TOT - 1));
  assign slot_end = run && last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else begin
      cnt <= last ? '0 : cnt + CW'(1);
      sk  <= pulse_en && !last && ((cnt + CW'(1)) >= CW'(LO_CYC));
    end
  end

  // R8
  hi_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sk) |-> cnt == CW'(LO_CYC));

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(TOT));
endmodule

// File: rtl/mw_tx_shifter.sv
module mw_tx_shifter #(
  parameter int W  = 25,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  load_bits,
  input  logic [LW-1:0] load_len,
  input  logic          shift,
  output logic          msb,
  output logic          last
);
  logic [W-1:0]  sr;
  logic [LW-1:0] remain;

  assign msb  = sr[W-1];
  assign last = (remain == LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      remain <= '0;
    end else if (load) begin
      sr     <= load_bits;
      remain <= load_len;
    end else if (shift) begin
      sr     <= {sr[W-2:0], 1'b0};
      remain <= (remain == '0) ? '0 : remain - LW'(1);
    end
  end

  // R1
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));

  // R2
  shift_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    shift |-> remain != '0);
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int LO_CYC   = 25,
  parameter int HI_CYC   = 75,
  parameter int POLL_MAX = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W:0]   req_count,
  output logic              req_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              err,
  output logic              ee_cs,
  output logic              ee_clk,
  output logic              ee_dout,
  input  logic              ee_din
);
  localparam int FW    = LEAD_W + ADDR_W + WORD_W;
  localparam int LW    = $clog2(FW + 1);
  localparam int CNT_W = ADDR_W + 1;
  localparam int PW    = $clog2(POLL_MAX + 1);
  localparam int RXC_W = $clog2(RX_BITS + 1);
  localparam logic [LW-1:0]     CMD_LEN  = LW'(LEAD_W + ADDR_W);
  localparam logic [LW-1:0]     FULL_LEN = LW'(FW);
  localparam logic [ADDR_W-1:0] EN_FIELD = ADDR_W'(SPEC_WREN) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] DIS_FIELD = ADDR_W'(SPEC_WRDIS) << (ADDR_W - 2);

  mw_state_e         state;
  mw_kind_e          kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  left;
  logic [PW-1:0]     poll_cnt;
  logic [RXC_W-1:0]  rx_cnt;
  logic [WORD_W-1:0] rx_sr;

  logic              run, pulse_en, slot_end;
  logic              ld, tx_last, shift;
  logic [FW-1:0]     ld_bits;
  logic [LW-1:0]     ld_len;

  function automatic logic [FW-1:0] mk_frame(input logic [1:0] opc,
                                             input logic [ADDR_W-1:0] a,
                                             input logic [WORD_W-1:0] d);
    return {1'b1, opc, a, d};
  endfunction

  assign run      = (state == S_TX) || (state == S_RX) || (state == S_GAP) ||
                    (state == S_POLL) || (state == S_RST);
  assign pulse_en = (state != S_GAP);
  assign shift    = (state == S_TX) && slot_end;
  assign req_ready = (state == S_IDLE);
  assign wr_ready  = (state == S_FETCH);

  mw_slot_timer #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(run), .pulse_en(pulse_en),
    .sk(ee_clk), .slot_end(slot_end)
  );

  mw_tx_shifter #(.W(FW), .LW(LW)) u_shift (
    .clk(clk), .rst(rst), .load(ld), .load_bits(ld_bits), .load_len(ld_len),
    .shift(shift), .msb(ee_dout), .last(tx_last)
  );

  // Frame launch: which frame is loaded into the shifter, and when.
  always_comb begin
    ld      = 1'b0;
    ld_bits = '0;
    ld_len  = CMD_LEN;
    case (state)
      S_IDLE: if (req_valid && (req_count != '0)) begin
        ld      = 1'b1;
        ld_bits = req_write ? mk_frame(OPC_SPECIAL, EN_FIELD, '0)
                            : mk_frame(OPC_READ, req_addr, '0);
      end
      S_FETCH: if (wr_valid) begin
        ld      = 1'b1;
        ld_bits = mk_frame(OPC_WRITE, cur_addr, wr_data);
        ld_len  = FULL_LEN;
      end
      S_RST: if (slot_end) begin
        if (kind == K_RD && left != CNT_W'(1)) begin
          ld      = 1'b1;
          ld_bits = mk_frame(OPC_READ, cur_addr + ADDR_W'(1), '0);
        end else if (kind == K_WR && (err || left == CNT_W'(1))) begin
          ld      = 1'b1;
          ld_bits = mk_frame(OPC_SPECIAL, DIS_FIELD, '0);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind     <= K_RD;
      cur_addr <= '0;
      left     <= '0;
      poll_cnt <= '0;
      rx_cnt   <= '0;
      rx_sr    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      ee_cs    <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          left     <= req_count;
          err      <= 1'b0;
          if (req_count == '0) begin
            state <= S_FIN;
          end else begin
            kind  <= req_write ? K_EN : K_RD;
            ee_cs <= 1'b1;
            state <= S_TX;
          end
        end
        S_TX: if (slot_end && tx_last) begin
          case (kind)
            K_RD: begin
              state  <= S_RX;
              rx_cnt <= '0;
            end
            K_WR: begin
              state <= S_GAP;
              ee_cs <= 1'b0;
            end
            default: begin
              state <= S_RST;
              ee_cs <= 1'b0;
            end
          endcase
        end
        S_RX: if (slot_end) begin
          rx_sr  <= {rx_sr[WORD_W-2:0], ee_din};
          rx_cnt <= rx_cnt + RXC_W'(1);
          if (rx_cnt == RXC_W'(RX_BITS - 1)) begin
            rd_data  <= {rx_sr[WORD_W-2:0], ee_din};
            rd_valid <= 1'b1;
            state    <= S_RST;
            ee_cs    <= 1'b0;
          end
        end
        S_GAP: if (slot_end) begin
          state    <= S_POLL;
          ee_cs    <= 1'b1;
          poll_cnt <= '0;
        end
        S_POLL: if (slot_end) begin
          if (ee_din) begin
            state <= S_RST;
            ee_cs <= 1'b0;
          end else if (poll_cnt == PW'(POLL_MAX - 1)) begin
            err   <= 1'b1;
            state <= S_RST;
            ee_cs <= 1'b0;
          end else begin
            poll_cnt <= poll_cnt + PW'(1);
          end
        end
        S_RST: if (slot_end) begin
          case (kind)
            K_DIS: state <= S_FIN;
            K_EN:  state <= S_FETCH;
            K_RD: begin
              if (left == CNT_W'(1)) begin
                state <= S_FIN;
              end else begin
                left     <= left - CNT_W'(1);
                cur_addr <= cur_addr + ADDR_W'(1);
                ee_cs    <= 1'b1;
                state    <= S_TX;
              end
            end
            default: begin
              if (err || left == CNT_W'(1)) begin
                kind  <= K_DIS;
                ee_cs <= 1'b1;
                state <= S_TX;
              end else begin
                left     <= left - CNT_W'(1);
                cur_addr <= cur_addr + ADDR_W'(1);
                state    <= S_FETCH;
              end
            end
          endcase
        end
        S_FETCH: if (wr_valid) begin
          kind  <= K_WR;
          ee_cs <= 1'b1;
          state <= S_TX;
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  cs_dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ee_clk |-> $stable(ee_cs) && $stable(ee_dout));

  // R6
  gap_no_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP) |-> !ee_clk && !ee_cs);

  // R10
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL) |-> poll_cnt < PW'(POLL_MAX));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  rd_strobe_cs_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !ee_cs && !rd_valid_q);

  // R4
  wr_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> ee_cs && ee_dout && !wr_ready);

  logic rd_valid_q;
  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= rd_valid;
  end
endmodule

// File: tb/test_mw_eeprom_ctrl.sv
module test_mw_eeprom_ctrl;
  localparam int AW = 6;
  localparam int LO = 2;
  localparam int HI = 3;
  localparam int PMAX = 8;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [AW:0] req_count = '0;
  logic req_ready, wr_ready, rd_valid, done, err, ee_cs, ee_clk, ee_dout;
  logic [15:0] wr_data, rd_data;
  logic wr_valid = 1'b0;
  logic ee_din = 1'b0;

  always #5 clk = ~clk;

  mw_eeprom_ctrl #(.ADDR_W(AW), .LO_CYC(LO), .HI_CYC(HI), .POLL_MAX(PMAX)) i_mw_eeprom_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_count(req_count), .req_ready(req_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
    .ee_cs(ee_cs), .ee_clk(ee_clk), .ee_dout(ee_dout), .ee_din(ee_din)
  );

  int n_chk = 0, n_fail = 0;

  function automatic logic [15:0] fdata(int a);
    return 16'((a * 40503) ^ 'h5A5A ^ (a << 9));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- write data source ----------------
  int acc = 0, acc0 = 0, wr_base = 0;
  bit inv = 0;
  always @(posedge clk) if (wr_valid && wr_ready) acc <= acc + 1;
  always_comb wr_data = fdata((wr_base + acc - acc0) % NW) ^ (inv ? 16'hFFFF : 16'h0000);

  // ---------------- read capture ----------------
  logic [15:0] rd_got[256];
  int rd_n = 0;
  always @(negedge clk) if (rd_valid) begin rd_got[rd_n % 256] = rd_data; rd_n++; end

  // ---------------- device model ----------------
  localparam int M_HUNT = 0, M_HDR = 1, M_RD = 2, M_WD = 3, M_WROTE = 4, M_POLL = 5, M_IGN = 6;
  logic [15:0] mem[NW];
  logic [1:0]  log_op[256];
  logic [7:0]  log_ad[256];
  int log_n = 0, mode = M_HUNT, hcnt = 0, ridx = 0, wcnt = 0, bcnt = 0;
  int busy_k = 3, polls = 0, rst_pulses = 0;
  bit stuck = 0, wen = 0;
  logic [AW+1:0] hdr = '0;
  logic [AW-1:0] ad = '0;
  logic [15:0] wd = '0;

  always @(posedge ee_clk or negedge ee_cs) begin
    if (!ee_cs) begin
      if (ee_clk === 1'b1) rst_pulses++;
      else begin
        mode = (mode == M_WROTE) ? M_POLL : M_HUNT;
        ee_din = 1'b0;
      end
    end else begin
      case (mode)
        M_HUNT: if (ee_dout) begin mode = M_HDR; hcnt = 0; hdr = '0; end
        M_HDR: begin
          hdr = {hdr[AW:0], ee_dout};
          hcnt++;
          if (hcnt == AW + 2) begin
            ad = hdr[AW-1:0];
            log_op[log_n % 256] = hdr[AW+1:AW];
            log_ad[log_n % 256] = 8'(ad);
            log_n++;
            case (hdr[AW+1:AW])
              2'b10: begin mode = M_RD; ridx = 0; end
              2'b01: begin mode = M_WD; wcnt = 0; end
              2'b00: begin
                if (ad[AW-1:AW-2] == 2'b11) wen = 1;
                else if (ad[AW-1:AW-2] == 2'b00) wen = 0;
                mode = M_IGN;
              end
              default: mode = M_IGN;
            endcase
          end
        end
        M_RD: begin
          if (ridx == 0) ee_din = 1'b0;
          else if (ridx <= 16) ee_din = mem[ad][16-ridx];
          ridx++;
        end
        M_WD: begin
          wd = {wd[14:0], ee_dout};
          wcnt++;
          if (wcnt == 16) begin
            if (wen) mem[ad] = wd;
            mode = M_WROTE;
            bcnt = busy_k;
          end
        end
        M_POLL: begin
          polls++;
          if (!stuck && bcnt == 0) ee_din = 1'b1;
          else begin ee_din = 1'b0; if (bcnt != 0) bcnt--; end
        end
        default: ;
      endcase
    end
  end

  // ---------------- timing and gap monitor ----------------
  int run_len = 0, cs_low_len = 0, gaps = 0, tviol = 0;
  bit clk_in_low = 0;
  logic pclk = 0, pcs = 0, pdout = 0;
  always @(negedge clk) if (!rst) begin
    if (ee_clk && (ee_cs !== pcs || ee_dout !== pdout)) tviol++;
    if (ee_clk !== pclk) begin
      if (pclk && run_len != HI) tviol++;
      if (!pclk && run_len < LO) tviol++;
      run_len = 1;
    end else run_len++;
    if (!ee_cs) begin
      if (pcs) begin cs_low_len = 0; clk_in_low = 0; end
      cs_low_len++;
      if (ee_clk) clk_in_low = 1;
    end else if (!pcs) begin
      if (!clk_in_low && cs_low_len == LO + HI) gaps++;
    end
    pclk = ee_clk; pcs = ee_cs; pdout = ee_dout;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  task automatic do_req(bit wr, int a, int cnt);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_count = (AW+1)'(cnt);
    wr_valid = wr; wr_base = a; acc0 = acc;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    wr_valid = 1'b0;
  endtask

  int l0, r0, p0, g0, rs0, a0;

  task automatic snap();
    l0 = log_n; r0 = rd_n; p0 = polls; g0 = gaps; rs0 = rst_pulses; a0 = acc;
  endtask

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = 16'h0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 req_ready", req_ready, 1);
    chk("R12 ee_cs", ee_cs, 0);
    chk("R12 ee_clk", ee_clk, 0);
    chk("R12 done", done, 0);
    chk("R12 err", err, 0);
    chk("R12 wr_ready", wr_ready, 0);

    // R11 zero count
    snap();
    do_req(1, 3, 0);
    chk("R11 no frames", log_n - l0, 0);
    chk("R11 no reset pulses", rst_pulses - rs0, 0);
    chk("R11 err", err, 0);

    // Write sweep over the full address space
    busy_k = 3; stuck = 0; inv = 0;
    snap();
    do_req(1, 0, NW);
    chk("R5 frame count", log_n - l0, NW + 2);
    chk("R5 enable op", log_op[l0 % 256], 0);
    chk("R1 enable field", log_ad[l0 % 256], 8'h30);
    chk("R5 disable op", log_op[(l0 + NW + 1) % 256], 0);
    chk("R1 disable field", log_ad[(l0 + NW + 1) % 256], 0);
    for (int i = 0; i < NW; i++) begin
      chk("R1 write opcode", log_op[(l0 + 1 + i) % 256], 1);
      chk("R9 write address", log_ad[(l0 + 1 + i) % 256], i);
      chk("R4 stored word", mem[i], fdata(i));
    end
    chk("R4 words accepted", acc - a0, NW);
    chk("R6 poll pulses", polls - p0, NW * (busy_k + 1));
    chk("R6 cs gaps", gaps - g0, NW);
    chk("R7 reset pulses", rst_pulses - rs0, NW + 2);
    chk("R5 protected after", wen, 0);
    chk("R10 err", err, 0);

    // Read sweep
    snap();
    do_req(0, 0, NW);
    chk("R3 words returned", rd_n - r0, NW);
    for (int i = 0; i < NW; i++) begin
      chk("R3 read data", rd_got[(r0 + i) % 256], fdata(i));
      chk("R1 read opcode", log_op[(l0 + i) % 256], 2);
      chk("R2 read address", log_ad[(l0 + i) % 256], i);
    end
    chk("R7 reset pulses read", rst_pulses - rs0, NW);
    chk("R6 no gaps on read", gaps - g0, 0);

    // R9 wrap-around
    snap();
    do_req(0, NW - 2, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R9 wrap address", log_ad[(l0 + i) % 256], (NW - 2 + i) % NW);
      chk("R9 wrap data", rd_got[(r0 + i) % 256], fdata((NW - 2 + i) % NW));
    end

    // R10 boundary: ready on the last allowed poll
    busy_k = PMAX - 1; inv = 1;
    snap();
    do_req(1, 40, 1);
    chk("R10 ready on last poll err", err, 0);
    chk("R10 ready on last poll pulses", polls - p0, PMAX);
    chk("R4 inverted word", mem[40], 16'(~fdata(40)));

    // R10 timeout
    stuck = 1;
    snap();
    do_req(1, 5, 3);
    chk("R10 err set", err, 1);
    chk("R10 frames", log_n - l0, 3);
    chk("R10 write addr", log_ad[(l0 + 1) % 256], 5);
    chk("R10 disable sent", log_op[(l0 + 2) % 256] == 2'b00 && log_ad[(l0 + 2) % 256] == 0, 1);
    chk("R10 polls", polls - p0, PMAX);
    chk("R10 one word taken", acc - a0, 1);

    // R12 err cleared by next request
    stuck = 0;
    snap();
    do_req(0, 5, 1);
    chk("R12 err cleared", err, 0);
    chk("R3 read after timeout", rd_got[r0 % 256], 16'(~fdata(5)));

    // R8 serial timing over the whole run
    chk("R8 timing violations", tviol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule